// File: doc/BRIEF.md
# Card Clock Mode and Divider Selector

This block turns a requested card bus frequency into the settings a storage card clock generator needs. For each request it receives the frequency of the source clock, the target card frequency and a bus timing class (single data rate legacy, double data rate, or HS400). It returns a 2-bit clock mode code, an 8-bit divider field, a flag that puts the HS400 clock path into half-source mode, and the card frequency that those settings actually produce. The frequency it reports never exceeds the target, except when the divider field saturates.

A request is accepted on a one-cycle `start` while the block is idle. Most settings need two sequential divisions, so the block stays busy for a number of cycles that grows with the frequency width. A request that hits a fixed ratio (bypass, quarter rate or half rate) completes in two cycles. A one-cycle `done` marks a valid result. The results then hold until the next accepted request. The block does not gate the clock, sense clock stability or provide a register interface.

Top module: `card_clk_sel`

## Requirements
- R1: After reset, `busy`, `done`, `hs400_half`, `ck_mode`, `div_field` and `card_freq` are all zero.
- R2: With `timing` = 0 (legacy) and target >= source, the block returns `ck_mode` = 1 (bypass), `div_field` = 0 and `card_freq` = source.
- R3: With `timing` = 0 and target < source, the block returns `ck_mode` = 0 and `div_field` = min(ceil(source / (4*target)), 255). A target of 0 counts as an unbounded divisor. `card_freq` = floor(source / (4*div_field)).
- R4: With `timing` = 1 (DDR) and target >= floor(source/4), the block returns `ck_mode` = 2, `div_field` = 0 and `card_freq` = floor(source/4).
- R5: With `timing` = 1 and target below that threshold, let d = ceil(floor(source/2) / target), rounded up to the next even value. A target of 0 counts as an unbounded d. The block returns `ck_mode` = 2, `div_field` = min(d/2, 255) and `card_freq` = floor(floor(source/4) / (2*div_field)).
- R6: With `timing` = 2 (HS400), `ck_mode` is 3. If target >= floor(source/2), the block returns `hs400_half` = 1, `div_field` = 0 and `card_freq` = floor(source/2). Otherwise it applies the rules of R4 and R5 with `hs400_half` = 0.
- R7: `hs400_half` is 0 in the cycle after an accepted `start`, and it is only ever 1 together with `ck_mode` = 3 and `div_field` = 0.
- R8: `done` is a single-cycle pulse, and `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R9: A `start` while `busy` is high is ignored. The result of the request in flight is unaffected.
- R10: While the block is idle and no `start` is given, all result outputs hold their values.
- R11: `timing` = 3 behaves exactly as legacy (R2, R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| src_freq | input | FW | Source clock frequency |
| tgt_freq | input | FW | Requested card frequency |
| timing | input | 2 | 0 legacy, 1 DDR, 2 HS400, 3 legacy |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ck_mode | output | 2 | 0 divided, 1 bypass, 2 DDR, 3 HS400 |
| div_field | output | 8 | Divider field |
| hs400_half | output | 1 | HS400 half-source clock select |
| card_freq | output | FW | Resulting card frequency |

## Verification
The assertions check the handshake shape on every cycle: the `done` pulse width, `busy` around a request, the clearing of `hs400_half` after a new request, and holding while idle. They also check the structural pairings of the codes, such as bypass and half-rate with a zero divider. The arithmetic cannot be checked by a property. This covers the ceiling rounding, even rounding, saturation at 255, the boundaries where target meets source/4, source/2 or source, and the reported card frequency. Only the bench's sweep over source and target values in every timing class shows these, together with the ignored start during a busy request.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        TM_LEGACY = 2'd0,
        TM_DDR    = 2'd1,
        TM_HS400  = 2'd2,
        TM_RSVD   = 2'd3
    } timing_e;

    typedef enum logic [1:0] {
        CKM_DIV    = 2'd0,
        CKM_BYPASS = 2'd1,
        CKM_DDR    = 2'd2,
        CKM_HS400  = 2'd3
    } ckmode_e;

    localparam int FIELD_W = 8;
    localparam logic [FIELD_W-1:0] FIELD_MAX = '1;

    typedef struct packed {
        ckmode_e             mode;
        logic                half;
        logic [FIELD_W-1:0]  field;
    } clk_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_QUOT,
        ST_LAUNCH,
        ST_CARD,
        ST_FIN
    } sel_state_e;

    function automatic logic uses_ddr(timing_e t);
        return (t == TM_DDR) || (t == TM_HS400);
    endfunction

    function automatic ckmode_e ddr_code(timing_e t);
        return (t == TM_HS400) ? CKM_HS400 : CKM_DDR;
    endfunction

endpackage

// File: rtl/clksel_div.sv
// Sequential restoring divider: one quotient bit per cycle.
module clksel_div #(
    parameter int NW = 32,
    parameter int DW = 34
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          fin,
    output logic [NW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(NW + 1);

    logic          run;
    logic [CW-1:0] cnt;
    logic [NW-1:0] qs;
    logic [DW-1:0] ra;
    logic [DW-1:0] dq;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          take;

    always_comb begin
        trial = {ra, qs[NW-1]};
        take  = trial >= {1'b0, dq};
        diff  = trial - {1'b0, dq};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
            qs  <= '0;
            ra  <= '0;
            dq  <= '0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                run <= 1'b1;
                cnt <= '0;
                qs  <= num;
                ra  <= '0;
                dq  <= den;
            end else if (run) begin
                qs  <= {qs[NW-2:0], take};
                ra  <= take ? diff[DW-1:0] : trial[DW-1:0];
                cnt <= cnt + 1'b1;
                if (cnt == CW'(NW - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quo = qs;
    assign rem = ra;
endmodule

// File: rtl/clksel_plan.sv
// Decides fixed-ratio results and sets up the divisor division.
module clksel_plan
    import clksel_pkg::*;
#(
    parameter int FW = 32
) (
    input  timing_e         tim,
    input  logic [FW-1:0]   src,
    input  logic [FW-1:0]   tgt,
    output logic            fast,
    output clk_cfg_t        cfg,
    output logic [FW-1:0]   card,
    output logic [FW-1:0]   num,
    output logic [FW+1:0]   den
);
    always_comb begin
        fast      = 1'b0;
        cfg.mode  = CKM_DIV;
        cfg.half  = 1'b0;
        cfg.field = '0;
        card      = '0;
        num       = '0;
        den       = '0;
        if (uses_ddr(tim)) begin
            cfg.mode = ddr_code(tim);
            if (tim == TM_HS400 && tgt >= (src >> 1)) begin
                fast     = 1'b1;
                cfg.half = 1'b1;
                card     = src >> 1;
            end else if (tgt >= (src >> 2)) begin
                fast = 1'b1;
                card = src >> 2;
            end else begin
                num = src >> 1;
                den = {2'b00, tgt};
            end
        end else begin
            if (tgt >= src) begin
                fast     = 1'b1;
                cfg.mode = CKM_BYPASS;
                card     = src;
            end else begin
                num = src;
                den = {tgt, 2'b00};
            end
        end
    end
endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
    import clksel_pkg::*;
#(
    parameter int FW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] src_freq,
    input  logic [FW-1:0] tgt_freq,
    input  logic [1:0]    timing,
    output logic          busy,
    output logic          done,
    output logic [1:0]    ck_mode,
    output logic [7:0]    div_field,
    output logic          hs400_half,
    output logic [FW-1:0] card_freq
);
    localparam int DW = FW + 2;
    localparam int XW = FW + 2;

    sel_state_e     state;
    logic [FW-1:0]  src_q, tgt_q;
    timing_e        tim_q;
    clk_cfg_t       cfg_q;
    logic [FW-1:0]  card_q;
    logic           ddr_q;

    logic           plan_fast;
    clk_cfg_t       plan_cfg;
    logic [FW-1:0]  plan_card, plan_num;
    logic [DW-1:0]  plan_den;

    logic           dv_go, dv_fin;
    logic [FW-1:0]  dv_num, dv_quo;
    logic [DW-1:0]  dv_den, dv_rem;
    logic [FW-1:0]  card_num;
    logic [DW-1:0]  card_den;

    logic [XW-1:0]        d_ceil, d_even, d_pick;
    logic [FIELD_W-1:0]   field_sat;

    clksel_plan #(.FW(FW)) u_plan (
        .tim  (tim_q),
        .src  (src_q),
        .tgt  (tgt_q),
        .fast (plan_fast),
        .cfg  (plan_cfg),
        .card (plan_card),
        .num  (plan_num),
        .den  (plan_den)
    );

    clksel_div #(.NW(FW), .DW(DW)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (dv_go),
        .num (dv_num),
        .den (dv_den),
        .fin (dv_fin),
        .quo (dv_quo),
        .rem (dv_rem)
    );

    always_comb begin
        ddr_q    = uses_ddr(tim_q);
        card_num = ddr_q ? (src_q >> 2) : src_q;
        card_den = ddr_q ? DW'({cfg_q.field, 1'b0}) : DW'({cfg_q.field, 2'b00});
        dv_go    = ((state == ST_PLAN) && !plan_fast) || (state == ST_LAUNCH);
        dv_num   = (state == ST_PLAN) ? plan_num : card_num;
        dv_den   = (state == ST_PLAN) ? plan_den : card_den;
        // ceiling of the quotient, then even rounding for double data rate
        d_ceil   = XW'(dv_quo) + XW'(|dv_rem);
        d_even   = d_ceil + XW'(d_ceil[0]);
        d_pick   = ddr_q ? (d_even >> 1) : d_ceil;
        field_sat = (d_pick > XW'(FIELD_MAX)) ? FIELD_MAX : d_pick[FIELD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            src_q  <= '0;
            tgt_q  <= '0;
            tim_q  <= TM_LEGACY;
            cfg_q  <= '0;
            card_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    src_q      <= src_freq;
                    tgt_q      <= tgt_freq;
                    tim_q      <= timing_e'(timing);
                    cfg_q.half <= 1'b0;
                    state      <= ST_PLAN;
                end
                ST_PLAN: begin
                    if (plan_fast) begin
                        cfg_q  <= plan_cfg;
                        card_q <= plan_card;
                        state  <= ST_FIN;
                    end else begin
                        cfg_q.mode <= plan_cfg.mode;
                        cfg_q.half <= 1'b0;
                        state      <= ST_QUOT;
                    end
                end
                ST_QUOT: if (dv_fin) begin
                    cfg_q.field <= field_sat;
                    state       <= ST_LAUNCH;
                end
                ST_LAUNCH: state <= ST_CARD;
                ST_CARD: if (dv_fin) begin
                    card_q <= dv_quo;
                    state  <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_FIN);
    assign ck_mode    = cfg_q.mode;
    assign div_field  = cfg_q.field;
    assign hs400_half = cfg_q.half;
    assign card_freq  = card_q;
endmodule

// File: rtl/card_clk_sel_chk.sv
module card_clk_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] ck_mode,
    input logic [7:0] div_field,
    input logic       hs400_half
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                             // R8
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);                                              // R8
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                                  // R8
    AST_HALF_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !hs400_half);                           // R7
    AST_HALF_CODES: assert property (@(posedge clk) disable iff (rst)
        hs400_half |-> (ck_mode == 2'd3 && div_field == 8'd0));      // R7
    AST_BYPASS_NODIV: assert property (@(posedge clk) disable iff (rst)
        (!busy && ck_mode == 2'd1) |-> div_field == 8'd0);           // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(ck_mode) && $stable(div_field)
                               && $stable(hs400_half)));             // R10
endmodule

bind card_clk_sel card_clk_sel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .ck_mode    (ck_mode),
    .div_field  (div_field),
    .hs400_half (hs400_half)
);

// File: tb/tb_card_clk_sel.sv
`timescale 1ns/1ps
module tb_card_clk_sel;
    localparam int FW = 10;
    localparam int FMAX = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] src_freq = '0;
    logic [FW-1:0] tgt_freq = '0;
    logic [1:0]    timing = '0;
    logic          busy, done, hs400_half;
    logic [1:0]    ck_mode;
    logic [7:0]    div_field;
    logic [FW-1:0] card_freq;

    int nvec = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    card_clk_sel #(.FW(FW)) dut (
        .clk(clk), .rst(rst), .start(start), .src_freq(src_freq),
        .tgt_freq(tgt_freq), .timing(timing), .busy(busy), .done(done),
        .ck_mode(ck_mode), .div_field(div_field), .hs400_half(hs400_half),
        .card_freq(card_freq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model(input int s, input int t, input int tm,
                         output int em, output int eh, output int ef, output int ec);
        int d, h;
        eh = 0;
        if (tm == 1 || tm == 2) begin
            em = (tm == 2) ? 3 : 2;
            if (tm == 2 && t >= s / 2) begin
                eh = 1; ef = 0; ec = s / 2;
            end else if (t >= s / 4) begin
                ef = 0; ec = s / 4;
            end else begin
                h = s / 2;
                d = (t == 0) ? 100000 : (h + t - 1) / t;
                if (d % 2 == 1) d++;
                ef = (d / 2 > 255) ? 255 : d / 2;
                ec = (s / 4) / (2 * ef);
            end
        end else begin
            if (t >= s) begin
                em = 1; ef = 0; ec = s;
            end else begin
                em = 0;
                d = (t == 0) ? 100000 : (s + 4 * t - 1) / (4 * t);
                ef = (d > 255) ? 255 : d;
                ec = s / (4 * ef);
            end
        end
    endtask

    function automatic string req_of(input int tm, input int s, input int t);
        if (tm == 2) return "R6";
        if (tm == 1) return (t >= s / 4) ? "R4" : "R5";
        if (tm == 3) return "R11";
        return (t >= s) ? "R2" : "R3";
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_result(input int s, input int t, input int tm, input string tag);
        int em, eh, ef, ec;
        model(s, t, tm, em, eh, ef, ec);
        chk(ck_mode == em,    tag, "ck_mode",    ck_mode,    em);
        chk(hs400_half == eh, tag, "hs400_half", hs400_half, eh);
        chk(div_field == ef,  tag, "div_field",  div_field,  ef);
        chk(card_freq == ec,  tag, "card_freq",  card_freq,  ec);
    endtask

    task automatic run_vec(input int s, input int t, input int tm);
        bit seen;
        src_freq = FW'(s); tgt_freq = FW'(t); timing = 2'(tm); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(hs400_half == 1'b0, "R7", "half after start", hs400_half, 0);
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        wait_done(seen);
        chk(seen, "R8", "done seen", seen, 1);
        check_result(s, t, tm, req_of(tm, s, t));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "idle after done", done, 0);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int srcs[8] = '{0, 1, 3, 8, 100, 401, 1000, 1023};
        int extra[7];
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0, "R1", "busy/done", busy, 0);
        chk(ck_mode == 0 && div_field == 0, "R1", "mode/field", div_field, 0);
        chk(hs400_half == 0 && card_freq == 0, "R1", "half/card", card_freq, 0);

        for (int tm = 0; tm < 4; tm++) begin
            foreach (srcs[i]) begin
                int s;
                s = srcs[i];
                for (int t = 0; t <= FMAX; t += 31) run_vec(s, t, tm);
                extra = '{s, s - 1, s / 2, s / 2 - 1, s / 4, s / 4 - 1, s + 1};
                foreach (extra[j]) begin
                    if (extra[j] >= 0 && extra[j] <= FMAX) run_vec(s, extra[j], tm);
                end
            end
        end

        // R9: start while busy is ignored
        src_freq = FW'(1000); tgt_freq = FW'(7); timing = 2'd1; start = 1'b1;
        @(negedge clk);
        src_freq = FW'(50); tgt_freq = FW'(900); timing = 2'd0;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen, "R9", "done seen", seen, 1);
        check_result(1000, 7, 1, "R9");
        // R10: idle without start holds results
        repeat (5) @(negedge clk);
        check_result(1000, 7, 1, "R10");
        // R7: half flag raised then dropped by next request
        run_vec(800, 600, 2);
        chk(hs400_half == 1'b1, "R7", "half set", hs400_half, 1);
        run_vec(800, 20, 2);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule